// File: doc/BRIEF.md
# Sequential-Write Mapping Tracker

This block keeps a small on-controller table with one entry per logical flash block. Each host request carries an operation code, a byte address and a byte size. The block splits the address into a logical block number and a page offset within that block. It then reads the block's entry, decides the outcome, writes the updated entry back in the same cycle, and returns a registered response one cycle after the request is accepted.

An entry records the next expected write position and a flag that marks the block's mapping as optimal. While a block is optimal, writes must arrive strictly in page order from page 0, at exactly one page in size and page-aligned. A read of an optimal block then translates directly to the physical block id plus the page offset. Any other write pattern demotes the block. From then on, its traffic is reported as taking the best-effort path, until a trim erases it. The physical block id of each entry is fixed as a base value plus the logical block number.

The block is used in front of a flash controller's write path. It tells the rest of the controller whether a request can be served by direct translation, or whether it must take the general remapping path.

Top module: `seqmap_tracker`

## Requirements
- R1: With default parameters (4096-byte pages, 64 pages per block, 16 blocks), the logical block number is address bits [21:18], which is the address divided by 262144. The page offset is address bits [17:12], which is the remainder divided by 4096. The response page field always carries the page offset of the request.
- R2: After reset, every block is optimal with write position 0. The response physical id for block n is 0x100 + n. No response is valid after reset, and req_ready is 1.
- R3: A write (op code 1) to an optimal block is accepted in sequence when it is page-aligned, 4096 bytes in size and its page equals the write position. It returns status 0 (ok) with optimal 1 and advances the position by one.
- R4: A write to an optimal block is demoted when its page differs from the position (a skip or an update), its size is not one page, or its address has non-zero bits below bit 12. It returns status 3 (demoted) with optimal 0, and the block becomes non-optimal.
- R5: A write to an optimal block whose position equals the page count (64) returns status 4 (full error) with optimal 0, and the block becomes non-optimal. This holds even when the page and size would otherwise be in sequence.
- R6: A read or write to a non-optimal block returns status 2 (best effort) with optimal 0 and leaves the entry unchanged.
- R7: A read (op code 0) to an optimal block whose page is below the position returns status 0 with the block's physical id and the page offset. This holds in any order of pages.
- R8: A read to an optimal block whose page is at or beyond the position returns status 1 (unwritten) with optimal 1.
- R9: A trim (op code 2) sets the block's position to 0 and marks it optimal, and returns status 0 with optimal 1. The block can then be written again in sequence from page 0.
- R10: A request is accepted when req_valid and req_ready are both 1. req_ready equals (not rsp_valid) or rsp_ready. The response is valid in the cycle after acceptance and is held unchanged while rsp_ready is 0. A request accepted in the cycle right after a write sees that write's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 trim, 3 handled as read |
| req_addr | input | 22 | Byte address |
| req_size | input | 16 | Byte count of the request |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 3 | 0 ok, 1 unwritten, 2 best effort, 3 demoted, 4 full error |
| rsp_pbid | output | 22 | Physical block id of the addressed block |
| rsp_page | output | 6 | Page offset within the block |
| rsp_opt | output | 1 | Optimal flag of the block after the request |

## Verification
Two functions can meet in one cycle. The first is the table write-back of one request. The second is the table lookup of the next request to the same block, when that request is accepted on the very next clock. The bench provokes this by issuing a write and then, with no idle cycle, a read of the page just written. The read must report ok rather than unwritten.

A second collision comes from a held response meeting a new request. The bench stalls rsp_ready while a further request waits, and checks two things: req_ready stays low and the held response does not change. It also checks that the waiting request is served correctly once the stall ends.

// File: rtl/seqmap_pkg.sv
// Package: operation and status codes shared by the mapping tracker.
// Assumes: codes are fixed because the host and the bench decode them.
package seqmap_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_OK        = 3'd0,
        ST_UNWRITTEN = 3'd1,
        ST_BEST      = 3'd2,
        ST_DEMOTED   = 3'd3,
        ST_FULL      = 3'd4
    } status_e;

endpackage

// File: rtl/seqmap_addr_split.sv
// Module: seqmap_addr_split
// Splits a byte address into block number and page offset, and flags whether
// the request is exactly one page long and starts on a page boundary.
// Assumes: page and block sizes are powers of two, so division is a bit slice.
module seqmap_addr_split #(
    parameter int PAGE_LOG2  = 12,
    parameter int PAGES_LOG2 = 6,
    parameter int BLKS_LOG2  = 4,
    parameter int SIZE_W     = 16,
    localparam int ADDR_W    = PAGE_LOG2 + PAGES_LOG2 + BLKS_LOG2
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [SIZE_W-1:0]     size,
    output logic [BLKS_LOG2-1:0]  lbn,
    output logic [PAGES_LOG2-1:0] page,
    output logic                  aligned
);
    localparam logic [SIZE_W-1:0] PAGE_BYTES = SIZE_W'(1 << PAGE_LOG2);

    // Field extraction and page-shape test.
    always_comb begin
        lbn     = addr[ADDR_W-1 -: BLKS_LOG2];
        page    = addr[PAGE_LOG2 +: PAGES_LOG2];
        aligned = (addr[PAGE_LOG2-1:0] == '0) && (size == PAGE_BYTES);
    end
endmodule

// File: rtl/seqmap_judge.sv
// Module: seqmap_judge
// Decides the outcome of one request against the current entry of its block
// and produces the entry to write back.
// Assumes: cur_pos never exceeds the page count of a block.
module seqmap_judge
    import seqmap_pkg::*;
#(
    parameter int PAGES_LOG2 = 6,
    localparam int POS_W     = PAGES_LOG2 + 1,
    localparam int PAGES     = 1 << PAGES_LOG2
) (
    input  logic [1:0]            op,
    input  logic [POS_W-1:0]      cur_pos,
    input  logic                  cur_opt,
    input  logic [PAGES_LOG2-1:0] page,
    input  logic                  aligned,
    output logic [2:0]            status,
    output logic                  we,
    output logic [POS_W-1:0]      nxt_pos,
    output logic                  nxt_opt,
    output logic                  opt_after
);
    logic             full;
    logic [POS_W-1:0] page_ext;
    status_e          st;

    // Outcome decision for read, write and trim.
    always_comb begin
        full     = (cur_pos == POS_W'(PAGES));
        page_ext = {1'b0, page};
        st       = ST_OK;
        we       = 1'b0;
        nxt_pos  = cur_pos;
        nxt_opt  = cur_opt;
        case (op_e'(op))
            OP_WRITE: begin
                if (!cur_opt) begin
                    st = ST_BEST;
                end else if (full) begin
                    st      = ST_FULL;
                    we      = 1'b1;
                    nxt_opt = 1'b0;
                end else if (aligned && (page_ext == cur_pos)) begin
                    st      = ST_OK;
                    we      = 1'b1;
                    nxt_pos = cur_pos + 1'b1;
                end else begin
                    st      = ST_DEMOTED;
                    we      = 1'b1;
                    nxt_opt = 1'b0;
                end
            end
            OP_TRIM: begin
                st      = ST_OK;
                we      = 1'b1;
                nxt_pos = '0;
                nxt_opt = 1'b1;
            end
            default: begin
                if (!cur_opt)               st = ST_BEST;
                else if (page_ext < cur_pos) st = ST_OK;
                else                        st = ST_UNWRITTEN;
            end
        endcase
        status    = st;
        opt_after = we ? nxt_opt : cur_opt;
    end
endmodule

// File: rtl/seqmap_table.sv
// Module: seqmap_table
// Holds write position and optimal flag for every logical block, with one
// combinational read port and one write port on the same index.
// Physical ids are base plus block number; allocation lives elsewhere.
// Assumes: synchronous active-low reset erases every entry.
module seqmap_table #(
    parameter int                 BLKS_LOG2  = 4,
    parameter int                 PAGES_LOG2 = 6,
    parameter int                 PBID_W     = 22,
    parameter logic [PBID_W-1:0]  PBID_BASE  = 22'h100,
    localparam int                BLKS       = 1 << BLKS_LOG2,
    localparam int                POS_W      = PAGES_LOG2 + 1,
    localparam int                PAGES      = 1 << PAGES_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BLKS_LOG2-1:0] idx,
    input  logic                 we,
    input  logic [POS_W-1:0]     wr_pos,
    input  logic                 wr_opt,
    output logic [PBID_W-1:0]    rd_pbid,
    output logic [POS_W-1:0]     rd_pos,
    output logic                 rd_opt
);
    logic [POS_W-1:0] ent_pos [BLKS];
    logic [BLKS-1:0]  ent_opt;

    for (genvar i = 0; i < BLKS; i++) begin : g_ent
        // Per-entry storage: erase on reset, load on an indexed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_pos[i] <= '0;
                ent_opt[i] <= 1'b1;
            end else if (we && (idx == BLKS_LOG2'(i))) begin
                ent_pos[i] <= wr_pos;
                ent_opt[i] <= wr_opt;
            end
        end

        // R5
        pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ent_pos[i] <= POS_W'(PAGES));

        // R9
        wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == BLKS_LOG2'(i)) |=>
                (ent_pos[i] == $past(wr_pos) && ent_opt[i] == $past(wr_opt)));
    end

    // R2
    rst_erase_chk: assert property (@(posedge clk)
        !rst_n |=> (ent_opt == {BLKS{1'b1}}));

    // Read port and fixed physical id.
    always_comb begin
        rd_pos  = ent_pos[idx];
        rd_opt  = ent_opt[idx];
        rd_pbid = PBID_BASE + PBID_W'(idx);
    end
endmodule

// File: rtl/seqmap_tracker.sv
// Module: seqmap_tracker (top)
// Accepts read/write/trim requests, performs a one-cycle table
// read-modify-write and returns a registered response the next cycle.
// Assumes: one request in flight; the response is held under back-pressure.
module seqmap_tracker
    import seqmap_pkg::*;
#(
    parameter int                PAGE_LOG2  = 12,
    parameter int                PAGES_LOG2 = 6,
    parameter int                BLKS_LOG2  = 4,
    parameter int                SIZE_W     = 16,
    parameter int                PBID_W     = 22,
    parameter logic [PBID_W-1:0] PBID_BASE  = 22'h100,
    localparam int               ADDR_W     = PAGE_LOG2 + PAGES_LOG2 + BLKS_LOG2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_op,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [SIZE_W-1:0]     req_size,
    input  logic                  rsp_ready,
    output logic                  rsp_valid,
    output logic [2:0]            rsp_status,
    output logic [PBID_W-1:0]     rsp_pbid,
    output logic [PAGES_LOG2-1:0] rsp_page,
    output logic                  rsp_opt
);
    localparam int POS_W = PAGES_LOG2 + 1;

    logic [BLKS_LOG2-1:0]  lbn;
    logic [PAGES_LOG2-1:0] page;
    logic                  aligned;
    logic [PBID_W-1:0]     cur_pbid;
    logic [POS_W-1:0]      cur_pos;
    logic                  cur_opt;
    logic [2:0]            status;
    logic                  j_we;
    logic [POS_W-1:0]      nxt_pos;
    logic                  nxt_opt;
    logic                  opt_after;
    logic                  accept;

    seqmap_addr_split #(
        .PAGE_LOG2 (PAGE_LOG2),
        .PAGES_LOG2(PAGES_LOG2),
        .BLKS_LOG2 (BLKS_LOG2),
        .SIZE_W    (SIZE_W)
    ) u_split (
        .addr   (req_addr),
        .size   (req_size),
        .lbn    (lbn),
        .page   (page),
        .aligned(aligned)
    );

    seqmap_table #(
        .BLKS_LOG2 (BLKS_LOG2),
        .PAGES_LOG2(PAGES_LOG2),
        .PBID_W    (PBID_W),
        .PBID_BASE (PBID_BASE)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (lbn),
        .we     (j_we && accept),
        .wr_pos (nxt_pos),
        .wr_opt (nxt_opt),
        .rd_pbid(cur_pbid),
        .rd_pos (cur_pos),
        .rd_opt (cur_opt)
    );

    seqmap_judge #(
        .PAGES_LOG2(PAGES_LOG2)
    ) u_judge (
        .op       (req_op),
        .cur_pos  (cur_pos),
        .cur_opt  (cur_opt),
        .page     (page),
        .aligned  (aligned),
        .status   (status),
        .we       (j_we),
        .nxt_pos  (nxt_pos),
        .nxt_opt  (nxt_opt),
        .opt_after(opt_after)
    );

    // Handshake: take a request when the response slot is free or draining.
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
        accept    = req_valid && req_ready;
    end

    // Response register: load on accept, clear when drained, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= '0;
            rsp_pbid   <= '0;
            rsp_page   <= '0;
            rsp_opt    <= 1'b0;
        end else if (accept) begin
            rsp_valid  <= 1'b1;
            rsp_status <= status;
            rsp_pbid   <= cur_pbid;
            rsp_page   <= page;
            rsp_opt    <= opt_after;
        end else if (rsp_ready) begin
            rsp_valid  <= 1'b0;
        end
    end

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_status) && $stable(rsp_pbid) && $stable(rsp_page)));

    // R10
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R6
    best_nonopt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_BEST) |-> !rsp_opt);

    // R8
    unwr_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == ST_UNWRITTEN) |-> rsp_opt);

    // R4
    demote_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status == ST_DEMOTED || rsp_status == ST_FULL)) |-> !rsp_opt);
endmodule

// File: tb/seqmap_tracker_bench.sv
`timescale 1ns/1ps
module seqmap_tracker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_size = '0;
    logic        rsp_ready = 1'b1;
    logic        rsp_valid;
    logic [2:0]  rsp_status;
    logic [21:0] rsp_pbid;
    logic [5:0]  rsp_page;
    logic        rsp_opt;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    seqmap_tracker u_seqmap_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
        .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_pbid(rsp_pbid),
        .rsp_page(rsp_page), .rsp_opt(rsp_opt)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic [21:0] addr;
        logic [15:0] size;
        logic [2:0]  st;
        logic [21:0] pbid;
        logic [5:0]  page;
        logic        opt;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 2'd1, {4'd1, 6'd0, 12'd0},  16'd4096, 3'd0, 22'h101, 6'd0,  1'b1}, // R3
        '{4'd3, 2'd1, {4'd1, 6'd1, 12'd0},  16'd4096, 3'd0, 22'h101, 6'd1,  1'b1}, // R3
        '{4'd7, 2'd0, {4'd1, 6'd1, 12'd0},  16'd0,    3'd0, 22'h101, 6'd1,  1'b1}, // R7
        '{4'd7, 2'd0, {4'd1, 6'd0, 12'd0},  16'd0,    3'd0, 22'h101, 6'd0,  1'b1}, // R7
        '{4'd8, 2'd0, {4'd1, 6'd2, 12'd0},  16'd0,    3'd1, 22'h101, 6'd2,  1'b1}, // R8
        '{4'd8, 2'd0, {4'd1, 6'd63, 12'd0}, 16'd0,    3'd1, 22'h101, 6'd63, 1'b1}, // R8
        '{4'd4, 2'd1, {4'd1, 6'd3, 12'd0},  16'd4096, 3'd3, 22'h101, 6'd3,  1'b0}, // R4 skip
        '{4'd6, 2'd1, {4'd1, 6'd2, 12'd0},  16'd4096, 3'd2, 22'h101, 6'd2,  1'b0}, // R6
        '{4'd6, 2'd0, {4'd1, 6'd0, 12'd0},  16'd0,    3'd2, 22'h101, 6'd0,  1'b0}, // R6
        '{4'd9, 2'd2, {4'd1, 6'd0, 12'd0},  16'd0,    3'd0, 22'h101, 6'd0,  1'b1}, // R9
        '{4'd9, 2'd1, {4'd1, 6'd0, 12'd0},  16'd4096, 3'd0, 22'h101, 6'd0,  1'b1}, // R9
        '{4'd4, 2'd1, {4'd2, 6'd1, 12'd0},  16'd4096, 3'd3, 22'h102, 6'd1,  1'b0}, // R4 not page 0
        '{4'd4, 2'd1, {4'd3, 6'd0, 12'd0},  16'd512,  3'd3, 22'h103, 6'd0,  1'b0}, // R4 size
        '{4'd4, 2'd1, {4'd4, 6'd0, 12'd8},  16'd4096, 3'd3, 22'h104, 6'd0,  1'b0}, // R4 unaligned
        '{4'd3, 2'd1, {4'd5, 6'd0, 12'd0},  16'd4096, 3'd0, 22'h105, 6'd0,  1'b1}, // R3
        '{4'd4, 2'd1, {4'd5, 6'd0, 12'd0},  16'd4096, 3'd3, 22'h105, 6'd0,  1'b0}, // R4 update
        '{4'd2, 2'd0, {4'd0, 6'd0, 12'd0},  16'd0,    3'd1, 22'h100, 6'd0,  1'b1}, // R2
        '{4'd1, 2'd0, {4'd15, 6'd5, 12'd0}, 16'd0,    3'd1, 22'h10F, 6'd5,  1'b1}  // R1
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; returns at the next falling edge.
    task automatic issue(input logic [1:0] op, input logic [21:0] a, input logic [15:0] sz);
        req_op = op; req_addr = a; req_size = sz; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_rsp(input string tag, input logic [2:0] st, input logic [21:0] pb,
                             input logic [5:0] pg, input logic op_flag);
        check({tag, " valid"},  32'(rsp_valid),  32'd1);
        check({tag, " status"}, 32'(rsp_status), 32'(st));
        check({tag, " pbid"},   32'(rsp_pbid),   32'(pb));
        check({tag, " page"},   32'(rsp_page),   32'(pg));
        check({tag, " opt"},    32'(rsp_opt),    32'(op_flag));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state at the ports
        check("R2 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R10 req_ready after reset", 32'(req_ready), 32'd1);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].addr, VECS[i].size);
            check_rsp($sformatf("R%0d vec%0d", VECS[i].req, i),
                      VECS[i].st, VECS[i].pbid, VECS[i].page, VECS[i].opt);
        end

        // R5: fill block 6, then one more in-shape write
        for (int p = 0; p < 64; p++) begin
            issue(2'd1, {4'd6, 6'(p), 12'd0}, 16'd4096);
            check("R5 fill status", 32'(rsp_status), 32'd0);
        end
        issue(2'd1, {4'd6, 6'd0, 12'd0}, 16'd4096);
        check_rsp("R5 full write", 3'd4, 22'h106, 6'd0, 1'b0);
        issue(2'd0, {4'd6, 6'd0, 12'd0}, 16'd0);
        check_rsp("R5 read after full", 3'd2, 22'h106, 6'd0, 1'b0);

        // R10: back-to-back write then read of the same page
        req_op = 2'd1; req_addr = {4'd7, 6'd0, 12'd0}; req_size = 16'd4096; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_op = 2'd0; req_size = 16'd0;
        check_rsp("R10 b2b write", 3'd0, 22'h107, 6'd0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R10 b2b read sees write", 3'd0, 22'h107, 6'd0, 1'b1);

        // R10: response held under back-pressure while a request waits
        @(negedge clk);
        rsp_ready = 1'b0;
        req_op = 2'd1; req_addr = {4'd8, 6'd0, 12'd0}; req_size = 16'd4096; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_op = 2'd0; req_size = 16'd0;
        for (int k = 0; k < 3; k++) begin
            check("R10 stall ready low", 32'(req_ready), 32'd0);
            check_rsp("R10 stall held", 3'd0, 22'h108, 6'd0, 1'b1);
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R10 waiting read served", 3'd0, 22'h108, 6'd0, 1'b1);
        @(negedge clk);
        check("R10 drained", 32'(rsp_valid), 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule